// File: doc/BRIEF.md
# Soft-Start and Fault Sequencer

This block governs how a pulse-width-modulated power controller starts up and how it comes back after a fault. It holds a digital soft-start accumulator. The accumulator climbs in small steps while the controller is armed and fault-free. It descends in smaller steps while the controller is disarmed or any fault is active. The top bits of the accumulator form a code that a downstream PWM comparator uses as its duty-cycle ceiling.

A reset-dominant arming latch gates the drivers. Any active fault clears it. It can only be set again once the accumulator has dropped under a low threshold with no fault present. As a result, every recovery passes through a fresh, slow ramp.

Four fault flags are combined: overvoltage, undervoltage, overcurrent and reference fault. Each flag passes through a two-stage synchronizer. An optional hold mode makes an overvoltage event sticky until the block is reset.

Top module: `softstart_fault_seq`

## Requirements
- R1: While reset is asserted and in the first sample after it, `ss_code_o` is 0 and `drive_en_o` is 0.
- R2: While armed and fault-free, the accumulator grows by RISE_STEP (6) on every tick. It saturates at ACC_MAX = floor(10·2^ACC_W/11), which is 5.0 of a 5.5-unit full scale, and stays there. While rising, the code never decreases.
- R3: The accumulator changes only on ticks, one tick every PRESCALE clock cycles. From reset release, the code reaches its ceiling after about PRESCALE·ceil(ACC_MAX_code_bound/RISE_STEP) cycles.
- R4: While disarmed or faulted, the accumulator shrinks by FALL_STEP (2) per tick and saturates at 0.
- R5: A fault flag raised between clock edges forces `drive_en_o` low by the second rising edge that follows.
- R6: Arming happens only while the accumulator is below LOW_TH = floor(3·2^ACC_W/11) (1.5 units) with no synchronized fault. While a fault persists, `drive_en_o` stays 0 even when the accumulator is at 0.
- R7: After a fault ends, the accumulator keeps falling until it is below LOW_TH. Only then does `drive_en_o` return to 1, and the ramp restarts from there.
- R8: With `ov_hold_i` = 1, an overvoltage event keeps the block disarmed after the flag clears, until reset. Other faults still recover.
- R9: `ss_code_o` is bits [ACC_W-1 -: CODE_W] of the accumulator.
- R10: Each of the four fault flags on its own causes a shutdown and a recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ov_flag_i | input | 1 | Overvoltage fault flag |
| uv_flag_i | input | 1 | Undervoltage fault flag |
| oc_flag_i | input | 1 | Overcurrent fault flag |
| ref_flag_i | input | 1 | Reference fault flag |
| ov_hold_i | input | 1 | 1: overvoltage shutdown is sticky until reset |
| ss_code_o | output | CODE_W | Soft-start code (upper accumulator bits) |
| drive_en_o | output | 1 | Output-driver enable |

## Verification
Two events can land in the same cycle: a fault ending, and the accumulator crossing below the arming threshold. The arming latch must not treat the fault-free state as permission to arm while the accumulator is still above threshold. The bench provokes this by pulsing each fault flag briefly while the code sits at its ceiling. It then watches every cycle of the descent and flags any cycle in which the enable is high while the code is above the threshold code. It also checks that the enable returns once the code is at or under that code.

// File: rtl/ssf_pkg.sv
package ssf_pkg;

    localparam int unsigned NFLAG = 4;

    typedef enum logic [1:0] {
        FLT_OV  = 2'd0,
        FLT_UV  = 2'd1,
        FLT_OC  = 2'd2,
        FLT_REF = 2'd3
    } flt_idx_e;

    typedef enum logic {
        SLEW_DOWN = 1'b0,
        SLEW_UP   = 1'b1
    } slew_e;

    // num/den of the full-scale accumulator range, floored
    function automatic longint unsigned scale_frac(input int unsigned acc_w,
                                                   input int unsigned num,
                                                   input int unsigned den);
        return (longint'(num) << acc_w) / longint'(den);
    endfunction

endpackage

// File: rtl/ssf_fault_sync.sv
module ssf_fault_sync #(
    parameter int unsigned NFLAG       = ssf_pkg::NFLAG,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NFLAG-1:0] flags_i,
    input  logic             ov_hold_i,
    output logic             fault_o
);
    import ssf_pkg::*;

    localparam int unsigned LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NFLAG-1:0] stg;
        logic                              ov_lat;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = flags_i;
        for (int i = 1; i < int'(SYNC_STAGES); i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
        st_d.ov_lat = st_q.ov_lat | (ov_hold_i & st_q.stg[LAST][int'(FLT_OV)]);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = (|st_q.stg[LAST]) | st_q.ov_lat;

    AST_OV_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ov_lat |=> st_q.ov_lat); // R8

    AST_OV_LATCH_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.ov_lat) |-> $past(ov_hold_i)); // R8

endmodule

// File: rtl/ssf_ramp.sv
module ssf_ramp #(
    parameter int unsigned ACC_W     = 16,
    parameter int unsigned PRESCALE  = 64,
    parameter int unsigned RISE_STEP = 6,
    parameter int unsigned FALL_STEP = 2,
    parameter logic [ACC_W-1:0] ACC_MAX = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  ssf_pkg::slew_e   slew_i,
    output logic [ACC_W-1:0] acc_o
);
    import ssf_pkg::*;

    localparam int unsigned CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRESCALE - 1);
    localparam logic [ACC_W-1:0] RISE = ACC_W'(RISE_STEP);
    localparam logic [ACC_W-1:0] FALL = ACC_W'(FALL_STEP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
    } ramp_t;

    ramp_t st_d, st_q;
    logic  tick;
    logic [ACC_W-1:0] headroom;

    always_comb begin
        st_d     = st_q;
        tick     = (st_q.cnt == CNT_LAST);
        headroom = ACC_MAX - st_q.acc;
        st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        if (tick) begin
            if (slew_i == SLEW_UP) begin
                st_d.acc = (headroom <= RISE) ? ACC_MAX : st_q.acc + RISE;
            end else begin
                st_d.acc = (st_q.acc <= FALL) ? '0 : st_q.acc - FALL;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_o = st_q.acc;

    AST_NO_OVERSHOOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.acc <= ACC_MAX); // R2

    AST_TICK_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick |=> $stable(st_q.acc)); // R3

    AST_RISE_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && slew_i == SLEW_UP) |=> st_q.acc >= $past(st_q.acc)); // R2

    AST_FALL_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && slew_i == SLEW_DOWN) |=> st_q.acc <= $past(st_q.acc)); // R4

endmodule

// File: rtl/ssf_arm_latch.sv
module ssf_arm_latch #(
    parameter int unsigned ACC_W = 16,
    parameter logic [ACC_W-1:0] LOW_TH = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fault_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic             armed_o
);
    typedef struct packed {
        logic armed;
    } arm_t;

    arm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault_i) begin
            st_d.armed = 1'b0;            // reset side wins
        end else if (acc_i < LOW_TH) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign armed_o = st_q.armed;

    AST_ARM_BELOW_TH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.armed) |-> ($past(acc_i) < LOW_TH && !$past(fault_i))); // R6

    AST_FAULT_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_i |=> !st_q.armed); // R5

endmodule

// File: rtl/softstart_fault_seq.sv
module softstart_fault_seq #(
    parameter int unsigned ACC_W       = 16,
    parameter int unsigned CODE_W      = 8,
    parameter int unsigned PRESCALE    = 64,
    parameter int unsigned RISE_STEP   = 6,
    parameter int unsigned FALL_STEP   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ov_flag_i,
    input  logic              uv_flag_i,
    input  logic              oc_flag_i,
    input  logic              ref_flag_i,
    input  logic              ov_hold_i,
    output logic [CODE_W-1:0] ss_code_o,
    output logic              drive_en_o
);
    import ssf_pkg::*;

    // 5.0 and 1.5 units on a 5.5-unit full scale
    localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(scale_frac(ACC_W, 10, 11));
    localparam logic [ACC_W-1:0] LOW_TH  = ACC_W'(scale_frac(ACC_W, 3, 11));

    logic [NFLAG-1:0] flags;
    logic             fault;
    logic             armed;
    slew_e            slew;
    logic [ACC_W-1:0] acc;

    always_comb begin
        flags                = '0;
        flags[int'(FLT_OV)]  = ov_flag_i;
        flags[int'(FLT_UV)]  = uv_flag_i;
        flags[int'(FLT_OC)]  = oc_flag_i;
        flags[int'(FLT_REF)] = ref_flag_i;
    end

    ssf_fault_sync #(
        .NFLAG       (NFLAG),
        .SYNC_STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .flags_i   (flags),
        .ov_hold_i (ov_hold_i),
        .fault_o   (fault)
    );

    ssf_arm_latch #(
        .ACC_W  (ACC_W),
        .LOW_TH (LOW_TH)
    ) i_latch (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .fault_i (fault),
        .acc_i   (acc),
        .armed_o (armed)
    );

    assign slew = (armed && !fault) ? SLEW_UP : SLEW_DOWN;

    ssf_ramp #(
        .ACC_W     (ACC_W),
        .PRESCALE  (PRESCALE),
        .RISE_STEP (RISE_STEP),
        .FALL_STEP (FALL_STEP),
        .ACC_MAX   (ACC_MAX)
    ) i_ramp (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .slew_i (slew),
        .acc_o  (acc)
    );

    assign ss_code_o  = acc[ACC_W-1 -: CODE_W];
    assign drive_en_o = armed & ~fault;

    AST_FAULT_BLOCKS_ARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault |=> !drive_en_o); // R5

    AST_ENABLE_RISE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(drive_en_o) |-> $past(acc) < LOW_TH); // R7

endmodule

// File: tb/test_softstart_fault_seq.sv
module test_softstart_fault_seq;

    localparam int ACC_W  = 12;
    localparam int CODE_W = 8;
    localparam int PRESC  = 2;
    localparam int MAXV   = (10 << ACC_W) / 11;      // 3723
    localparam int LOWV   = (3 << ACC_W) / 11;       // 1117
    localparam int MAXC   = MAXV >> (ACC_W - CODE_W); // 232
    localparam int LOWC   = LOWV >> (ACC_W - CODE_W); // 69

    logic clk = 1'b0;
    logic rst_n;
    logic [3:0] fl;
    logic hold;
    logic [CODE_W-1:0] code;
    logic en;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    softstart_fault_seq #(
        .ACC_W(ACC_W), .CODE_W(CODE_W), .PRESCALE(PRESC),
        .RISE_STEP(6), .FALL_STEP(2), .SYNC_STAGES(2)
    ) i_softstart_fault_seq (
        .clk_i(clk), .rst_ni(rst_n),
        .ov_flag_i(fl[0]), .uv_flag_i(fl[1]), .oc_flag_i(fl[2]), .ref_flag_i(fl[3]),
        .ov_hold_i(hold), .ss_code_o(code), .drive_en_o(en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // wait for code ceiling while checking monotonic rise; returns cycles
    task automatic ramp_up(output int t, output int drops);
        int prev;
        t = 0; drops = 0; prev = int'(code);
        while (int'(code) != MAXC && t < 5000) begin
            @(negedge clk);
            t++;
            if (int'(code) < prev) drops++;
            prev = int'(code);
        end
    endtask

    initial begin
        int t, drops, viol, prev;
        rst_n = 1'b0; fl = '0; hold = 1'b0;
        repeat (5) @(negedge clk);
        chk(code == 0, "R1 code in reset", int'(code), 0);
        chk(en == 1'b0, "R1 enable in reset", int'(en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(code == 0, "R1 code after release", int'(code), 0);

        // first ramp: 619 ticks of 6 reach the ceiling code, ticks every 2 cycles
        ramp_up(t, drops);
        t++;
        chk(t >= 1234 && t <= 1242, "R3 ramp duration", t, 1238);
        chk(drops == 0, "R2 monotonic rise", drops, 0);
        chk(en == 1'b1, "R6 armed after start", int'(en), 1);
        chk(int'(code) == MAXC, "R9 ceiling code", int'(code), MAXC);
        repeat (400) @(negedge clk);
        chk(int'(code) == MAXC, "R2 clamp holds", int'(code), MAXC);

        // sustained undervoltage
        fl[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(en == 1'b0, "R5 enable off two edges after fault", int'(en), 0);
        t = 2;
        while (int'(code) > LOWC && t < 10000) begin
            @(negedge clk);
            t++;
        end
        chk(t >= 2600 && t <= 2612, "R4 fall duration", t, 2606);
        repeat (6000) @(negedge clk);
        chk(code == 0, "R4 floor at zero", int'(code), 0);
        chk(en == 1'b0, "R6 no arming while fault held", int'(en), 0);
        fl[1] = 1'b0;
        t = 0;
        while (!en && t < 20) begin
            @(negedge clk);
            t++;
        end
        chk(en == 1'b1 && t <= 5, "R7 re-arm after fault clears at zero", t, 3);
        ramp_up(t, drops);
        chk(int'(code) == MAXC, "R2 reaches ceiling again", int'(code), MAXC);

        // each flag alone, short pulse at the ceiling
        for (int k = 0; k < 4; k++) begin
            fl[k] = 1'b1;
            @(negedge clk);
            @(negedge clk);
            chk(en == 1'b0, $sformatf("R10 flag %0d shuts down", k), int'(en), 0);
            @(negedge clk);
            fl[k] = 1'b0;
            viol = 0; t = 0; prev = int'(code);
            while (!en && t < 10000) begin
                @(negedge clk);
                t++;
                if (en && int'(code) > LOWC) viol++;
                if (!en && int'(code) > prev) viol++;
                prev = int'(code);
            end
            chk(viol == 0, $sformatf("R7 no early re-arm flag %0d", k), viol, 0);
            chk(en == 1'b1 && int'(code) <= LOWC, $sformatf("R7 re-arm below threshold flag %0d", k),
                int'(code), LOWC);
            ramp_up(t, drops);
            chk(int'(code) == MAXC && drops == 0, $sformatf("R10 recovery flag %0d", k), int'(code), MAXC);
        end

        // sticky overvoltage
        hold = 1'b1;
        fl[0] = 1'b1;
        repeat (3) @(negedge clk);
        fl[0] = 1'b0;
        repeat (8000) @(negedge clk);
        chk(en == 1'b0, "R8 overvoltage stays latched", int'(en), 0);
        chk(code == 0, "R8 code discharged while latched", int'(code), 0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(en == 1'b1, "R8 reset clears latch", int'(en), 1);
        fl[2] = 1'b1;
        repeat (3) @(negedge clk);
        fl[2] = 1'b0;
        t = 0;
        while (!en && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk(en == 1'b1, "R8 non-overvoltage fault recovers in hold mode", int'(en), 1);

        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        summary();
        $finish;
    end

endmodule